// File: doc/BRIEF.md
# Polled Priority Interrupt Controller

This block gathers eight interrupt request lines and presents them to a processor as one interrupt output. Software configures it through a byte-wide register port with a single address bit. A command byte with bit 4 set, written to address 0, opens a short configuration sequence that continues on address 1. Once that sequence is complete, address 1 holds the mask register. Further command bytes written to address 0 end service on a level, change which level has the lowest priority, pick which register address 0 reads back, or arm a poll.

Service works by polling, not by acknowledge bus cycles. After software arms a poll, its next read of address 0 returns a status byte that names the highest-priority serviceable level. That same read marks the level as in service. Priority rotates under software control. Nested service is respected: a level is only presented when it outranks every level that is in service. A request pulse that vanishes before service is never marked in service. Software can confirm this case by reading back the in-service register.

Top module: `prio_irq_poll`

## Requirements
- R1: After reset the mask register reads 0xFF at address 1, the request register reads 0x00 at address 0, and `irq_out` stays low even while a request line is high, because configuration has not been done.
- R2: A write to address 0 with bit 4 set starts configuration and clears the mask and in-service registers. It also restores the default priority (line 0 highest, line 7 lowest) and selects the request register for reads. The following address-1 writes are taken as a vector byte, then a cascade byte (skipped when bit 1 of the start word is 1), then a mode byte (only when bit 0 of the start word is 1). Only after the last of these is the block ready. `irq_out` is held low until then, and the next address-1 write loads the mask.
- R3: When ready, an address-1 write loads the mask and an address-1 read returns it. A 1 in bit n blocks line n from `irq_out` and from the poll. A masked line is still recorded in the request register.
- R4: Each request line passes two synchronizer flops. A rising edge sets its request bit. The bit clears when the line falls or when a poll grants it. A line held high after its grant does not request again.
- R5: An address-0 write of 0b110_00_LLL makes level LLL the lowest priority. The order then runs upward from LLL+1, modulo 8.
- R6: `irq_out` is high exactly when some unmasked pending level outranks every level that is in service.
- R7: An address-0 write with bits 4:3 = 01 and bit 2 set arms a poll, and the next address-0 read returns the status byte. If a level L is serviceable the byte is 0x80 | L, and that read sets in-service bit L and clears request bit L. Otherwise the byte is 0x00 and nothing changes. Bits 6:3 of the status byte are always 0, and a poll read disarms the poll.
- R8: An address-0 write with bits 4:3 = 01 and bits 1:0 = 10 selects the request register for later address-0 reads. With bits 1:0 = 11 it selects the in-service register.
- R9: An address-0 write of 0b011_00_LLL clears in-service bit LLL only. If a lower-priority request is still pending, `irq_out` rises again right after that write.
- R10: An address-0 write of 0x20 clears the highest-priority in-service bit under the current priority order.
- R11: An address-0 write of 0b111_00_LLL clears in-service bit LLL and makes LLL the lowest priority.
- R12: If bit 1 of the mode byte is 1, a poll grant clears the request bit but leaves the in-service register unchanged.
- R13: A pulse on line 7 that ends before any poll leaves the poll status at 0x00 and in-service bit 7 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_in | input | 8 | Asynchronous request lines |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; poll side effects occur on the clock edge |
| addr | input | 1 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational from addr and state) |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
A wrong request or in-service bit shows on `irq_out` in the same cycle, because the output is combinational from those registers. It also shows in the status byte of the very next poll. A wrong lowest-priority value stays hidden until two requests compete, so the tests raise pairs of lines before and after each priority change and compare the level order the polls return. A fault in the synchronizer or the edge logic shows as a request that appears on the wrong edge, or one that comes back while a line is held high. The bench therefore checks pending state only after a settled number of cycles, and checks again after each grant.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int NLINE     = 8;
    localparam int LW        = $clog2(NLINE);
    localparam int DW        = 8;
    localparam int SYNC_STG  = 2;

    typedef logic [LW-1:0]    lvl_t;
    typedef logic [NLINE-1:0] line_vec_t;
    typedef logic [DW-1:0]    byte_t;

    typedef enum logic [2:0] {
        ST_UNCONF,
        ST_VEC,
        ST_CASC,
        ST_MODE,
        ST_READY
    } cfg_st_t;

    typedef enum logic [2:0] {
        WK_NONE,
        WK_START,
        WK_OP2,
        WK_OP3,
        WK_DATA
    } wr_kind_t;

    typedef struct packed {
        wr_kind_t kind;
        byte_t    val;
    } wr_cmd_t;

    localparam logic [2:0] OP_NSEOI  = 3'b001;
    localparam logic [2:0] OP_SEOI   = 3'b011;
    localparam logic [2:0] OP_SETLOW = 3'b110;
    localparam logic [2:0] OP_ROTSEO = 3'b111;

    function automatic wr_cmd_t classify_write(input logic we, input logic a,
                                               input byte_t d);
        wr_cmd_t c;
        c.val = d;
        if (!we)       c.kind = WK_NONE;
        else if (a)    c.kind = WK_DATA;
        else if (d[4]) c.kind = WK_START;
        else if (d[3]) c.kind = WK_OP3;
        else           c.kind = WK_OP2;
        return c;
    endfunction

    function automatic lvl_t line_at_rank(input lvl_t lowest, input int unsigned k);
        return lvl_t'(lowest + lvl_t'(1) + lvl_t'(k));
    endfunction
endpackage

// File: rtl/pic_req_front.sv
module pic_req_front
    import pic_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  line_vec_t req_in,
    input  line_vec_t grant,
    output line_vec_t irr
);
    generate
        for (genvar i = 0; i < NLINE; i++) begin : g_line
            logic [SYNC_STG-1:0] chain;
            logic                prev;
            logic                level;
            logic                rise;

            assign level = chain[SYNC_STG-1];
            assign rise  = level & ~prev;

            always_ff @(posedge clk) begin
                if (rst) begin
                    chain  <= '0;
                    prev   <= 1'b0;
                    irr[i] <= 1'b0;
                end else begin
                    chain  <= {chain[SYNC_STG-2:0], req_in[i]};
                    prev   <= level;
                    irr[i] <= (irr[i] | rise) & level & ~grant[i];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/pic_rank.sv
module pic_rank
    import pic_pkg::*;
(
    input  line_vec_t irr,
    input  line_vec_t imr_eff,
    input  line_vec_t isr,
    input  lvl_t      lowest,
    output logic      req_hit,
    output lvl_t      req_lvl,
    output logic      isr_any,
    output lvl_t      isr_lvl
);
    line_vec_t pend;
    logic      p_found;
    lvl_t      p_rank;
    lvl_t      i_rank;

    assign pend = irr & ~imr_eff;

    always_comb begin
        p_found = 1'b0;
        p_rank  = '0;
        req_lvl = '0;
        isr_any = 1'b0;
        i_rank  = '0;
        isr_lvl = '0;
        for (int k = NLINE - 1; k >= 0; k--) begin
            if (pend[line_at_rank(lowest, k)]) begin
                p_found = 1'b1;
                p_rank  = lvl_t'(k);
                req_lvl = line_at_rank(lowest, k);
            end
            if (isr[line_at_rank(lowest, k)]) begin
                isr_any = 1'b1;
                i_rank  = lvl_t'(k);
                isr_lvl = line_at_rank(lowest, k);
            end
        end
        req_hit = p_found && (!isr_any || (p_rank < i_rank));
    end
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
    import pic_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  logic      rd_en,
    input  logic      addr,
    input  byte_t     wdata,
    input  line_vec_t irr,
    input  logic      req_hit,
    input  lvl_t      req_lvl,
    input  logic      isr_any,
    input  lvl_t      isr_lvl,
    output line_vec_t imr,
    output line_vec_t isr,
    output lvl_t      lowest,
    output logic      ready,
    output logic      poll_armed,
    output line_vec_t grant,
    output byte_t     rdata
);
    cfg_st_t   st;
    logic      want_mode;
    logic      solo;
    logic      auto_eoi;
    logic      show_isr;
    wr_cmd_t   wc;
    logic      poll_rd;
    logic      poll_ok;
    line_vec_t isr_n;
    lvl_t      lowest_n;
    byte_t     status;
    logic [2:0] op;
    lvl_t      op_lvl;

    assign wc      = classify_write(wr_en, addr, wdata);
    assign op      = wdata[7:5];
    assign op_lvl  = wdata[LW-1:0];
    assign ready   = (st == ST_READY);
    assign poll_rd = rd_en && !addr && poll_armed;
    assign poll_ok = poll_rd && req_hit;
    assign grant   = poll_ok ? (line_vec_t'(1) << req_lvl) : '0;
    assign status  = req_hit ? {1'b1, (DW - 1 - LW)'(0), req_lvl} : '0;

    always_comb begin
        if (addr)            rdata = imr;
        else if (poll_armed) rdata = status;
        else if (show_isr)   rdata = isr;
        else                 rdata = irr;
    end

    always_comb begin
        isr_n    = isr;
        lowest_n = lowest;
        if (poll_ok && !auto_eoi) isr_n[req_lvl] = 1'b1;
        if (wc.kind == WK_OP2) begin
            unique case (op)
                OP_NSEOI:  if (isr_any) isr_n[isr_lvl] = 1'b0;
                OP_SEOI:   isr_n[op_lvl] = 1'b0;
                OP_SETLOW: lowest_n = op_lvl;
                OP_ROTSEO: begin
                    isr_n[op_lvl] = 1'b0;
                    lowest_n      = op_lvl;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_UNCONF;
            imr        <= '1;
            isr        <= '0;
            lowest     <= lvl_t'(NLINE - 1);
            want_mode  <= 1'b0;
            solo       <= 1'b0;
            auto_eoi   <= 1'b0;
            show_isr   <= 1'b0;
            poll_armed <= 1'b0;
        end else if (wc.kind == WK_START) begin
            st         <= ST_VEC;
            imr        <= '0;
            isr        <= '0;
            lowest     <= lvl_t'(NLINE - 1);
            want_mode  <= wdata[0];
            solo       <= wdata[1];
            auto_eoi   <= 1'b0;
            show_isr   <= 1'b0;
            poll_armed <= 1'b0;
        end else begin
            isr    <= isr_n;
            lowest <= lowest_n;
            if (poll_rd) poll_armed <= 1'b0;
            if (wc.kind == WK_OP3) begin
                if (wdata[2]) poll_armed <= 1'b1;
                if (wdata[1]) show_isr <= wdata[0];
            end
            if (wc.kind == WK_DATA) begin
                unique case (st)
                    ST_VEC:  st <= !solo ? ST_CASC : (want_mode ? ST_MODE : ST_READY);
                    ST_CASC: st <= want_mode ? ST_MODE : ST_READY;
                    ST_MODE: begin
                        auto_eoi <= wdata[1];
                        st       <= ST_READY;
                    end
                    default: imr <= wdata;
                endcase
            end
        end
    end
endmodule

// File: rtl/prio_irq_poll.sv
module prio_irq_poll
    import pic_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] req_in,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic       addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq_out
);
    line_vec_t irr;
    line_vec_t imr;
    line_vec_t isr;
    line_vec_t grant;
    line_vec_t imr_eff;
    lvl_t      lowest;
    lvl_t      req_lvl;
    lvl_t      isr_lvl;
    logic      req_hit;
    logic      isr_any;
    logic      ready;
    logic      poll_armed;

    assign imr_eff = ready ? imr : '1;
    assign irq_out = req_hit;

    pic_req_front u_front (
        .clk    (clk),
        .rst    (rst),
        .req_in (req_in),
        .grant  (grant),
        .irr    (irr)
    );

    pic_rank u_rank (
        .irr     (irr),
        .imr_eff (imr_eff),
        .isr     (isr),
        .lowest  (lowest),
        .req_hit (req_hit),
        .req_lvl (req_lvl),
        .isr_any (isr_any),
        .isr_lvl (isr_lvl)
    );

    pic_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wdata      (wdata),
        .irr        (irr),
        .req_hit    (req_hit),
        .req_lvl    (req_lvl),
        .isr_any    (isr_any),
        .isr_lvl    (isr_lvl),
        .imr        (imr),
        .isr        (isr),
        .lowest     (lowest),
        .ready      (ready),
        .poll_armed (poll_armed),
        .grant      (grant),
        .rdata      (rdata)
    );
endmodule

// File: rtl/pic_poll_chk.sv
module pic_poll_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       rd_en,
    input logic       addr,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic       irq_out,
    input logic [7:0] irr,
    input logic [7:0] imr,
    input logic [7:0] isr,
    input logic       ready,
    input logic       poll_armed
);
    // R1, R2: no interrupt before configuration completes
    a_r1_irq_needs_ready: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> ready);

    // R2: start word clears mask and in-service state
    a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !addr && wdata[4]) |=> (isr == 8'h00 && imr == 8'h00 && !ready));

    // R3: nothing unmasked pending means no interrupt
    a_r3_mask_blocks: assert property (@(posedge clk) disable iff (rst)
        ((irr & ~imr) == 8'h00) |-> !irq_out);

    // R7: status byte middle bits are zero
    a_r7_poll_format: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !addr && poll_armed) |-> (rdata[6:3] == 4'b0000));

    // R7: empty poll leaves in-service untouched
    a_r7_empty_poll_keeps_isr: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !addr && poll_armed && !rdata[7] && !wr_en) |=> $stable(isr));

    // R7: poll read disarms the poll
    a_r7_poll_disarms: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !addr && poll_armed && !wr_en) |=> !poll_armed);

    // R9: specific end of service clears the named bit
    a_r9_seoi_clears: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !addr && wdata[7:3] == 5'b01100 && !rd_en) |=> !isr[$past(wdata[2:0])]);
endmodule

bind prio_irq_poll pic_poll_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .irq_out    (irq_out),
    .irr        (irr),
    .imr        (imr),
    .isr        (isr),
    .ready      (ready),
    .poll_armed (poll_armed)
);

// File: tb/tb_prio_irq_poll.sv
module tb_prio_irq_poll;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] req_in = 8'h00;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    prio_irq_poll dut (
        .clk(clk), .rst(rst), .req_in(req_in), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #(CLK_P/4);
        d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic lines(input logic [7:0] v);
        @(negedge clk);
        req_in = v;
        idle(5);
    endtask

    task automatic poll_expect(input string tag, input logic [7:0] exp);
        logic [7:0] d;
        wr(1'b0, 8'h0C);
        rd(1'b0, d);
        chk(tag, d, exp);
    endtask

    task automatic isr_expect(input string tag, input logic [7:0] exp);
        logic [7:0] d;
        wr(1'b0, 8'h0B);
        rd(1'b0, d);
        chk(tag, d, exp);
    endtask

    task automatic irr_expect(input string tag, input logic [7:0] exp);
        logic [7:0] d;
        wr(1'b0, 8'h0A);
        rd(1'b0, d);
        chk(tag, d, exp);
    endtask

    task automatic configure;
        wr(1'b0, 8'h11);
        wr(1'b1, 8'h00);
        wr(1'b1, 8'h04);
        wr(1'b1, 8'h01);
        wr(1'b1, 8'h00);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        rd(1'b1, d);
        chk("R1 mask after reset", d, 8'hFF);
        rd(1'b0, d);
        chk("R1 request reg after reset", d, 8'h00);
        lines(8'h01);
        chk("R1 irq low before config", {7'd0, irq_out}, 8'h00);
        lines(8'h00);
    endtask

    task automatic t_basic;
        configure();
        lines(8'h08);
        chk("R6 R4 irq on edge line3", {7'd0, irq_out}, 8'h01);
        poll_expect("R7 poll line3", 8'h83);
        chk("R6 irq low while in service", {7'd0, irq_out}, 8'h00);
        isr_expect("R8 isr read", 8'h08);
        irr_expect("R4 held level no rerequest", 8'h00);
        wr(1'b0, 8'h63);
        isr_expect("R9 seoi clears bit3", 8'h00);
        chk("R4 held line stays quiet", {7'd0, irq_out}, 8'h00);
        lines(8'h00);
        poll_expect("R7 empty poll", 8'h00);
    endtask

    task automatic t_mask;
        logic [7:0] d;
        wr(1'b1, 8'h20);
        rd(1'b1, d);
        chk("R3 mask readback", d, 8'h20);
        lines(8'h20);
        chk("R3 masked line no irq", {7'd0, irq_out}, 8'h00);
        irr_expect("R3 masked line recorded", 8'h20);
        wr(1'b1, 8'h00);
        chk("R3 unmask raises irq", {7'd0, irq_out}, 8'h01);
        poll_expect("R7 poll line5", 8'h85);
        wr(1'b0, 8'h65);
        lines(8'h00);
    endtask

    task automatic t_rotate;
        lines(8'h12);
        poll_expect("R5 default order line1 first", 8'h81);
        wr(1'b0, 8'h61);
        poll_expect("R5 default order then line4", 8'h84);
        wr(1'b0, 8'h64);
        lines(8'h00);
        wr(1'b0, 8'hC2);
        lines(8'h12);
        poll_expect("R5 lowest2 line4 first", 8'h84);
        wr(1'b0, 8'h64);
        poll_expect("R5 lowest2 then line1", 8'h81);
        wr(1'b0, 8'h61);
        lines(8'h00);
    endtask

    task automatic t_nesting;
        lines(8'h08);
        poll_expect("R7 nest line3", 8'h83);
        lines(8'h48);
        chk("R6 lower line blocked", {7'd0, irq_out}, 8'h00);
        wr(1'b0, 8'h63);
        chk("R9 irq reasserts after seoi", {7'd0, irq_out}, 8'h01);
        poll_expect("R9 poll line6", 8'h86);
        lines(8'h68);
        chk("R6 higher line passes", {7'd0, irq_out}, 8'h01);
        poll_expect("R6 poll line5", 8'h85);
        isr_expect("R7 two in service", 8'h60);
        wr(1'b0, 8'h20);
        isr_expect("R10 nseoi clears highest", 8'h40);
        wr(1'b0, 8'h20);
        isr_expect("R10 nseoi clears last", 8'h00);
        lines(8'h00);
    endtask

    task automatic t_reinit;
        logic [7:0] d;
        lines(8'h01);
        poll_expect("R7 line0 before restart", 8'h80);
        wr(1'b1, 8'h0F);
        wr(1'b0, 8'h11);
        rd(1'b1, d);
        chk("R2 restart clears mask", d, 8'h00);
        lines(8'h11);
        chk("R2 irq low during config", {7'd0, irq_out}, 8'h00);
        wr(1'b1, 8'h00);
        wr(1'b1, 8'h04);
        chk("R2 irq low before mode byte", {7'd0, irq_out}, 8'h00);
        wr(1'b1, 8'h01);
        chk("R2 irq after config", {7'd0, irq_out}, 8'h01);
        isr_expect("R2 restart clears isr", 8'h00);
        poll_expect("R7 line4 after restart", 8'h84);
        wr(1'b0, 8'h64);
        lines(8'h00);
        lines(8'h12);
        poll_expect("R2 default priority restored", 8'h81);
        wr(1'b0, 8'h61);
        poll_expect("R2 then line4", 8'h84);
        wr(1'b0, 8'h64);
        lines(8'h00);
    endtask

    task automatic t_rot_seoi;
        lines(8'h03);
        poll_expect("R11 line0 first", 8'h80);
        wr(1'b0, 8'hE0);
        isr_expect("R11 clears bit0", 8'h00);
        poll_expect("R11 line1 next", 8'h81);
        wr(1'b0, 8'h61);
        lines(8'h00);
        lines(8'h03);
        poll_expect("R11 line0 now lowest", 8'h81);
        wr(1'b0, 8'h61);
        poll_expect("R11 then line0", 8'h80);
        wr(1'b0, 8'h60);
        lines(8'h00);
    endtask

    task automatic t_spurious;
        @(negedge clk);
        req_in = 8'h80;
        @(negedge clk);
        req_in = 8'h00;
        idle(6);
        chk("R13 no irq after pulse", {7'd0, irq_out}, 8'h00);
        poll_expect("R13 poll empty", 8'h00);
        isr_expect("R13 isr7 clear", 8'h00);
    endtask

    task automatic t_solo_auto;
        logic [7:0] d;
        wr(1'b0, 8'h13);
        wr(1'b1, 8'h00);
        wr(1'b1, 8'h02);
        wr(1'b1, 8'h5A);
        rd(1'b1, d);
        chk("R2 solo sequence then mask", d, 8'h5A);
        wr(1'b1, 8'h00);
        lines(8'h04);
        poll_expect("R12 poll line2", 8'h82);
        isr_expect("R12 auto eoi isr empty", 8'h00);
        chk("R12 no irq after grant", {7'd0, irq_out}, 8'h00);
        lines(8'h00);
        wr(1'b0, 8'h12);
        wr(1'b1, 8'h00);
        wr(1'b1, 8'h3C);
        rd(1'b1, d);
        chk("R2 no mode byte sequence", d, 8'h3C);
        wr(1'b1, 8'h00);
        lines(8'h04);
        poll_expect("R12 auto eoi cleared by restart", 8'h82);
        isr_expect("R12 isr set without auto eoi", 8'h04);
        wr(1'b0, 8'h62);
        lines(8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle(2);
        t_reset();
        t_basic();
        t_mask();
        t_rotate();
        t_nesting();
        t_reinit();
        t_rot_seoi();
        t_spurious();
        t_solo_auto();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule